// File: doc/BRIEF.md
# SIMT Divergent Branch Fork Unit

This block carries out a conditional fork for a 64-lane SIMT wavefront. A caller presents the active lane mask, a per-lane condition mask read from a scalar register pair, the program counter of the fork instruction and a signed 16-bit offset. The block returns the next lane mask, the next program counter and the next control-stack pointer. When the lanes split, it also stores the deferred path as one control-stack entry in the scalar register file.

The block forms two lane groups. The passing lanes are the active lanes whose condition bit is 1. The failing lanes are the active lanes whose condition bit is 0. If only one group is non-empty, the wavefront moves as a whole. If both groups are non-empty, the smaller group runs first. The mask and resume address of the other group are written through a single-dword register write port. The write covers four consecutive register indices, starting at the stack pointer times four. The stack pointer is a 3-bit field that lives in the low bits of the mode register. It is passed in with each request and comes back incremented after a push. A push that would be made from the last slot is refused, and a sticky overflow flag is raised instead.

Requests are accepted only while the unit is idle. The `busy` output holds the issue side off until the one-cycle `done` pulse, and the results are valid during that pulse.

Top module: `branch_fork_top`

## Requirements
- R1: When every active lane passes (execIn & condIn == execIn, including an all-zero execIn), the result is pcOut = pcIn + 4 + sign-extended offsetIn, execOut = execIn, cspOut = cspIn, and no register write occurs.
- R2: When every active lane fails (execIn & ~condIn == execIn with execIn non-zero), the result is pcOut = pcIn + 4, execOut = execIn, cspOut = cspIn, and no register write occurs.
- R3: When both groups are non-empty and the failing group has strictly fewer lanes, execOut is set to the failing lanes and pcOut = pcIn + 4. The pushed entry holds the passing mask and the branch target.
- R4: When both groups are non-empty and the passing group is not larger than the failing group (a tie included), execOut is set to the passing lanes and pcOut is the branch target. The pushed entry holds the failing mask and pcIn + 4.
- R5: offsetIn is a two's-complement value. A negative offset yields a target below pcIn + 4.
- R6: A push makes exactly four writes on consecutive cycles, with sgprWe high, at index cspIn*4 + k. The words are: k=0 mask bits 31:0, k=1 mask bits 63:32, k=2 address bits 31:0, k=3 address bits 63:32. After the push, cspOut = cspIn + 1.
- R7: A request is accepted on a rising edge with issueValid high while busy is low. busy rises at that edge. done is seen 2 cycles after acceptance without a push, and 6 cycles after acceptance with a push. issueValid has no effect while busy is high.
- R8: When a push is needed and cspIn equals 7, overflow is set and no register write occurs. cspOut = 7, execOut = execIn, and pcOut = pcIn, so the fork can be re-run after a trap. done is seen 2 cycles after acceptance.
- R9: After reset, busy, done, sgprWe and overflow are 0. Once set, overflow stays 1 through later requests until the next reset.
- R10: done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Fork request, sampled while idle |
| execIn | input | 64 | Current active lane mask |
| condIn | input | 64 | Per-lane condition from a register pair |
| pcIn | input | 64 | Address of the fork instruction |
| offsetIn | input | 16 | Signed branch offset |
| cspIn | input | 3 | Current control-stack pointer |
| busy | output | 1 | Request in progress, new requests held off |
| done | output | 1 | One-cycle completion pulse, results valid |
| execOut | output | 64 | Next active lane mask |
| pcOut | output | 64 | Next program counter |
| cspOut | output | 3 | Next control-stack pointer |
| overflow | output | 1 | Sticky stack overflow flag |
| sgprWe | output | 1 | Scalar register write enable |
| sgprAddr | output | 7 | Scalar register index |
| sgprData | output | 32 | Scalar register write data |

## Verification
The assertions assume that the environment keeps the operands steady only up to the accepting edge. They also assume that the environment does not expect a second acceptance until `done` has been seen. They make no assumption about issueValid while the unit is busy, and the stimulus deliberately raises it during a push with different operands. Every request is driven on the falling edge and released after one accepting edge. The stimulus uses only register-sourced conditions and keeps cspIn within 0 to 7, so the overflow path is reached only through the legal maximum pointer value.

// File: rtl/fork_pkg.sv
package fork_pkg;
  localparam int LANES    = 64;
  localparam int PC_W     = 64;
  localparam int OFF_W    = 16;
  localparam int CSP_W    = 3;
  localparam int DW       = 32;
  localparam int ENTRY_DW = (LANES + PC_W) / DW;
  localparam int BEAT_W   = $clog2(ENTRY_DW);
  localparam int SGPR_AW  = 7;

  typedef enum logic [1:0] {
    PATH_ALL_PASS,
    PATH_ALL_FAIL,
    PATH_FAIL_FIRST,
    PATH_PASS_FIRST
  } path_e;

  typedef struct packed {
    logic              load;
    logic              commit;
    logic              push;
    logic [BEAT_W-1:0] beat;
  } strobe_t;
endpackage

// File: rtl/fork_datapath.sv
module fork_datapath
  import fork_pkg::*;
#(
  parameter int LANES_P   = LANES,
  parameter int PC_W_P    = PC_W,
  parameter int OFF_W_P   = OFF_W,
  parameter int CSP_W_P   = CSP_W,
  parameter int SGPR_AW_P = SGPR_AW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [LANES_P-1:0]   execIn,
  input  logic [LANES_P-1:0]   condIn,
  input  logic [PC_W_P-1:0]    pcIn,
  input  logic [OFF_W_P-1:0]   offsetIn,
  input  logic [CSP_W_P-1:0]   cspIn,
  output logic                 needPush,
  output logic                 cspFull,
  output logic [LANES_P-1:0]   execOut,
  output logic [PC_W_P-1:0]    pcOut,
  output logic [CSP_W_P-1:0]   cspOut,
  output logic                 overflow,
  output logic                 sgprWe,
  output logic [SGPR_AW_P-1:0] sgprAddr,
  output logic [DW-1:0]        sgprData
);
  localparam int CNT_W   = $clog2(LANES_P + 1);
  localparam int WORDS   = (LANES_P + PC_W_P) / DW;

  logic [LANES_P-1:0] execR, condR;
  logic [PC_W_P-1:0]  pcR;
  logic [OFF_W_P-1:0] offR;
  logic [CSP_W_P-1:0] cspR;

  logic [LANES_P-1:0] passMask, failMask, newExec, pushMask;
  logic [CNT_W-1:0]   passCnt, failCnt;
  logic [PC_W_P-1:0]  seqPc, targetPc, newPc, pushAddr;
  path_e              path;

  logic [LANES_P-1:0] execOutR;
  logic [PC_W_P-1:0]  pcOutR;
  logic [CSP_W_P-1:0] cspOutR;
  logic               ovfR;

  // operand capture at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      execR <= '0; condR <= '0; pcR <= '0; offR <= '0; cspR <= '0;
    end else if (strb.load) begin
      execR <= execIn; condR <= condIn; pcR <= pcIn;
      offR  <= offsetIn; cspR <= cspIn;
    end
  end

  assign passMask = execR & condR;
  assign failMask = execR & ~condR;

  always_comb begin
    passCnt = '0;
    failCnt = '0;
    for (int i = 0; i < LANES_P; i++) begin
      passCnt = passCnt + CNT_W'(passMask[i]);
      failCnt = failCnt + CNT_W'(failMask[i]);
    end
  end

  assign seqPc    = pcR + PC_W_P'(4);
  assign targetPc = seqPc + {{(PC_W_P-OFF_W_P){offR[OFF_W_P-1]}}, offR};

  always_comb begin
    if (passMask == execR)      path = PATH_ALL_PASS;
    else if (failMask == execR) path = PATH_ALL_FAIL;
    else if (failCnt < passCnt) path = PATH_FAIL_FIRST;
    else                        path = PATH_PASS_FIRST;
  end

  always_comb begin
    newExec  = execR;
    newPc    = targetPc;
    pushMask = passMask;
    pushAddr = targetPc;
    unique case (path)
      PATH_ALL_PASS:   newPc = targetPc;
      PATH_ALL_FAIL:   newPc = seqPc;
      PATH_FAIL_FIRST: begin
        newExec  = failMask;
        newPc    = seqPc;
        pushMask = passMask;
        pushAddr = targetPc;
      end
      PATH_PASS_FIRST: begin
        newExec  = passMask;
        newPc    = targetPc;
        pushMask = failMask;
        pushAddr = seqPc;
      end
      default: newPc = targetPc;
    endcase
  end

  assign needPush = (path == PATH_FAIL_FIRST) || (path == PATH_PASS_FIRST);
  assign cspFull  = (cspR == {CSP_W_P{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      execOutR <= '0; pcOutR <= '0; cspOutR <= '0; ovfR <= 1'b0;
    end else if (strb.commit) begin
      if (needPush && cspFull) begin
        ovfR     <= 1'b1;
        execOutR <= execR;
        pcOutR   <= pcR;
        cspOutR  <= cspR;
      end else begin
        execOutR <= newExec;
        pcOutR   <= newPc;
        cspOutR  <= needPush ? cspR + CSP_W_P'(1) : cspR;
      end
    end
  end

  // stack entry split into dwords, lowest index first
  logic [LANES_P+PC_W_P-1:0] entryBits;
  logic [DW-1:0]             entryWord [WORDS];
  assign entryBits = {pushAddr, pushMask};

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign entryWord[w] = entryBits[w*DW +: DW];
  end

  assign sgprWe   = strb.push;
  assign sgprAddr = SGPR_AW_P'(cspR) * SGPR_AW_P'(WORDS) + SGPR_AW_P'(strb.beat);
  assign sgprData = entryWord[strb.beat];

  assign execOut  = execOutR;
  assign pcOut    = pcOutR;
  assign cspOut   = cspOutR;
  assign overflow = ovfR;

  p_exec_subset_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> ((execOutR & ~$past(execR)) == '0));

  p_no_write_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    sgprWe |-> !cspFull);

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfR |=> ovfR);
endmodule

// File: rtl/fork_control.sv
module fork_control
  import fork_pkg::*;
#(
  parameter int BEATS = ENTRY_DW
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    issueValid,
  input  logic    needPush,
  input  logic    cspFull,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_PUSH, S_FIN} state_e;

  state_e            stateR, stateNx;
  logic [BEAT_W-1:0] beatR, beatNx;

  always_comb begin
    stateNx = stateR;
    beatNx  = beatR;
    unique case (stateR)
      S_IDLE: if (issueValid) stateNx = S_EVAL;
      S_EVAL: begin
        beatNx  = '0;
        stateNx = (needPush && !cspFull) ? S_PUSH : S_FIN;
      end
      S_PUSH: begin
        if (beatR == LAST_BEAT) stateNx = S_FIN;
        else                    beatNx  = beatR + BEAT_W'(1);
      end
      S_FIN:  stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= S_IDLE;
      beatR  <= '0;
    end else begin
      stateR <= stateNx;
      beatR  <= beatNx;
    end
  end

  assign strb.load   = (stateR == S_IDLE) && issueValid;
  assign strb.commit = (stateR == S_EVAL);
  assign strb.push   = (stateR == S_PUSH);
  assign strb.beat   = beatR;
  assign busy        = (stateR != S_IDLE);
  assign done        = (stateR == S_FIN);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_beats_back_to_back_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.beat != LAST_BEAT) |=> strb.push);

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
endmodule

// File: rtl/branch_fork_top.sv
module branch_fork_top
  import fork_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [LANES-1:0]    execIn,
  input  logic [LANES-1:0]    condIn,
  input  logic [PC_W-1:0]     pcIn,
  input  logic [OFF_W-1:0]    offsetIn,
  input  logic [CSP_W-1:0]    cspIn,
  output logic                busy,
  output logic                done,
  output logic [LANES-1:0]    execOut,
  output logic [PC_W-1:0]     pcOut,
  output logic [CSP_W-1:0]    cspOut,
  output logic                overflow,
  output logic                sgprWe,
  output logic [SGPR_AW-1:0]  sgprAddr,
  output logic [DW-1:0]       sgprData
);
  strobe_t strb;
  logic    needPush, cspFull;

  fork_control #(.BEATS(ENTRY_DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .needPush(needPush), .cspFull(cspFull),
    .strb(strb), .busy(busy), .done(done)
  );

  fork_datapath #(
    .LANES_P(LANES), .PC_W_P(PC_W), .OFF_W_P(OFF_W),
    .CSP_W_P(CSP_W), .SGPR_AW_P(SGPR_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .execIn(execIn), .condIn(condIn), .pcIn(pcIn),
    .offsetIn(offsetIn), .cspIn(cspIn),
    .needPush(needPush), .cspFull(cspFull),
    .execOut(execOut), .pcOut(pcOut), .cspOut(cspOut),
    .overflow(overflow), .sgprWe(sgprWe),
    .sgprAddr(sgprAddr), .sgprData(sgprData)
  );
endmodule

// File: tb/branch_fork_top_test.sv
`timescale 1ns/1ps
module branch_fork_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [63:0] execIn = '0, condIn = '0, pcIn = '0;
  logic [15:0] offsetIn = '0;
  logic [2:0]  cspIn = '0;
  logic        busy, done, overflow, sgprWe;
  logic [63:0] execOut, pcOut;
  logic [2:0]  cspOut;
  logic [6:0]  sgprAddr;
  logic [31:0] sgprData;

  int compared = 0;
  int mismatched = 0;
  logic expOvf = 1'b0;

  logic [6:0]  wAddr [8];
  logic [31:0] wData [8];
  int          wCnt;
  int          lat;

  always #4 clk = ~clk;

  branch_fork_top uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .execIn(execIn), .condIn(condIn), .pcIn(pcIn), .offsetIn(offsetIn),
    .cspIn(cspIn), .busy(busy), .done(done), .execOut(execOut),
    .pcOut(pcOut), .cspOut(cspOut), .overflow(overflow), .sgprWe(sgprWe),
    .sgprAddr(sgprAddr), .sgprData(sgprData)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive one request, collect writes and latency up to done
  task automatic runFork(input logic [63:0] e, input logic [63:0] c,
                         input logic [63:0] p, input logic [15:0] o,
                         input logic [2:0] cs, input bit pokeBusy);
    @(negedge clk);
    execIn = e; condIn = c; pcIn = p; offsetIn = o; cspIn = cs;
    issueValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (pokeBusy) begin
      execIn = ~e; condIn = ~c; pcIn = p + 64'h100; cspIn = cs + 3'd1;
    end else begin
      issueValid = 1'b0;
    end
    wCnt = 0;
    lat  = 1;
    for (int k = 0; k < 20; k++) begin
      if (done) break;
      @(negedge clk);
      lat++;
      if (sgprWe && wCnt < 8) begin
        wAddr[wCnt] = sgprAddr;
        wData[wCnt] = sgprData;
        wCnt++;
      end
    end
    issueValid = 1'b0;
  endtask

  // expected outcome from the requirements, then compare
  task automatic checkFork(input string tag, input logic [63:0] e,
                           input logic [63:0] c, input logic [63:0] p,
                           input logic [15:0] o, input logic [2:0] cs);
    logic [63:0] pass, fail, tgt, xExec, xPc, pMask, pAddr;
    bit          push;
    logic [2:0]  xCsp;
    pass = e & c;
    fail = e & ~c;
    tgt  = p + 64'd4 + {{48{o[15]}}, o};
    push = 1'b0;
    pMask = '0; pAddr = '0;
    if (pass == e) begin
      xExec = e; xPc = tgt;
    end else if (fail == e) begin
      xExec = e; xPc = p + 64'd4;
    end else if ($countones(fail) < $countones(pass)) begin
      xExec = fail; xPc = p + 64'd4; push = 1'b1; pMask = pass; pAddr = tgt;
    end else begin
      xExec = pass; xPc = tgt; push = 1'b1; pMask = fail; pAddr = p + 64'd4;
    end
    xCsp = cs;
    if (push && cs == 3'd7) begin
      expOvf = 1'b1; push = 1'b0; xExec = e; xPc = p;
    end else if (push) begin
      xCsp = cs + 3'd1;
    end
    chk(tag, "done latency", 64'(lat), push ? 64'd6 : 64'd2);
    chk(tag, "execOut", execOut, xExec);
    chk(tag, "pcOut", pcOut, xPc);
    chk(tag, "cspOut", 64'(cspOut), 64'(xCsp));
    chk(tag, "overflow", 64'(overflow), 64'(expOvf));
    chk(tag, "R6 write count", 64'(wCnt), push ? 64'd4 : 64'd0);
    if (push && wCnt == 4) begin
      for (int k = 0; k < 4; k++)
        chk(tag, "R6 write index", 64'(wAddr[k]), 64'(cs) * 4 + 64'(k));
      chk(tag, "R6 mask low", 64'(wData[0]), 64'(pMask[31:0]));
      chk(tag, "R6 mask high", 64'(wData[1]), 64'(pMask[63:32]));
      chk(tag, "R6 addr low", 64'(wData[2]), 64'(pAddr[31:0]));
      chk(tag, "R6 addr high", 64'(wData[3]), 64'(pAddr[63:32]));
    end
    @(negedge clk);
    chk("R10", "done after pulse", 64'(done), 64'd0);
    chk("R7", "busy after completion", 64'(busy), 64'd0);
  endtask

  task automatic doFork(input string tag, input logic [63:0] e, input logic [63:0] c,
                        input logic [63:0] p, input logic [15:0] o, input logic [2:0] cs);
    runFork(e, c, p, o, cs, 1'b0);
    checkFork(tag, e, c, p, o, cs);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R9", "busy at reset", 64'(busy), 64'd0);
    chk("R9", "done at reset", 64'(done), 64'd0);
    chk("R9", "sgprWe at reset", 64'(sgprWe), 64'd0);
    chk("R9", "overflow at reset", 64'(overflow), 64'd0);
  endtask

  task automatic testAllPass();
    doFork("R1 all pass", 64'h0000_FFFF_0000_00F0, 64'hFFFF_FFFF_0F0F_00F0,
           64'h0000_0000_0000_1000, 16'h0040, 3'd2);
  endtask

  task automatic testEmptyExec();
    doFork("R1 empty exec", 64'h0, 64'h1234_5678_9ABC_DEF0,
           64'h0000_0000_0000_2000, 16'h0010, 3'd1);
  endtask

  task automatic testAllFail();
    doFork("R2 all fail", 64'hFF00_0000_0000_00FF, 64'h00FF_FFFF_FFFF_FF00,
           64'h0000_0000_0000_3000, 16'h0100, 3'd3);
  endtask

  task automatic testFailFirst();
    // 3 failing lanes against 61 passing
    doFork("R3 fail group smaller", 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFC,
           64'h0000_0001_0000_4000, 16'h0200, 3'd2);
  endtask

  task automatic testPassFirst();
    doFork("R4 pass group smaller", 64'hFFFF_0000_FFFF_0000, 64'h0001_0000_8000_0000,
           64'h0000_0002_8000_0000, 16'h0080, 3'd5);
  endtask

  task automatic testTie();
    doFork("R4 tie", 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_00F0,
           64'h0000_0000_0000_5000, 16'h0020, 3'd0);
  endtask

  task automatic testNegOffset();
    doFork("R5 negative offset", 64'hF0F0_F0F0_F0F0_F0F0, 64'h0000_0000_0000_0001,
           64'h0000_0000_0000_6000, 16'hFF00, 3'd0);
    doFork("R5 negative offset jump", 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0003,
           64'h0000_0000_0000_0100, 16'h8000, 3'd4);
  endtask

  task automatic testBusyIgnore();
    logic [63:0] e, c, p;
    e = 64'h00FF_00FF_00FF_00FF;
    c = 64'h0000_00FF_0000_0001;
    p = 64'h0000_0000_0000_7000;
    runFork(e, c, p, 16'h0030, 3'd6, 1'b1);
    checkFork("R7 issue while busy", e, c, p, 16'h0030, 3'd6);
    @(negedge clk);
    chk("R7", "no second acceptance", 64'(busy), 64'd0);
  endtask

  task automatic testOverflow();
    doFork("R8 overflow", 64'hFFFF_FFFF_0000_0000, 64'h0000_0003_0000_0000,
           64'h0000_0000_0000_8000, 16'h0044, 3'd7);
  endtask

  task automatic testSticky();
    doFork("R9 sticky overflow", 64'h0000_0000_0000_000F, 64'h0000_0000_0000_0000,
           64'h0000_0000_0000_9000, 16'h0004, 3'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAllPass();
    testEmptyExec();
    testAllFail();
    testFailFirst();
    testPassFirst();
    testTie();
    testNegOffset();
    testBusyIgnore();
    testOverflow();
    testSticky();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule